// File: doc/BRIEF.md
# Parallel-to-Serial Word Shifter

This block turns a byte-wide parallel word into a bit stream, one bit per shift strobe. A load strobe captures a new word into an internal shift register. Each later shift strobe moves the register one place toward the serial output, and a bit counter tracks how many bits of the word are still to be sent. A runtime select picks whether the most significant or the least significant bit leaves first.

A feeding state machine, such as a serial-peripheral master, watches the busy output and holds its next word until the current one has fully drained. A load that arrives while bits are still pending is refused. When load and shift arrive together on an idle shifter, the load wins. A synchronous clear input lets a serial-peripheral slave flush the shifter on its select line, separately from the global reset.

Top module: `word_serializer`

## Requirements
- R1: After reset, `busy_o` is 0 and `ser_o` is 0.
- R2: A load on an idle shifter captures `data_i`, and `busy_o` is 1 from the next cycle on.
- R3: With `lsb_first_i`=0, `ser_o` shows data bit 7 right after the load, then bits 6 down to 0 after successive shifts.
- R4: With `lsb_first_i`=1, `ser_o` shows data bit 0 right after the load, then bits 1 up to 7 after successive shifts.
- R5: Positions vacated by shifting fill with 0, so `ser_o` is 0 once all eight bits have been shifted out.
- R6: A load while `busy_o`=1 is refused: the pending word and its remaining bit count are unchanged, and a shift in the same cycle still advances the pending word.
- R7: Load and shift asserted together on an idle shifter perform the load only; the first serial bit is still the word's head bit.
- R8: A shift while idle has no effect: `busy_o` stays 0 and `ser_o` keeps its value.
- R9: `busy_o` stays 1 through seven shifts and drops to 0 the cycle after the eighth shift.
- R10: `clr_i` empties the shifter on the next clock edge (`busy_o`=0, `ser_o`=0) and takes priority over a load or shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear, used on slave-select |
| lsb_first_i | input | 1 | 1 selects least-significant-bit first order |
| load_i | input | 1 | Load strobe for `data_i` |
| shift_i | input | 1 | Shift strobe |
| data_i | input | 8 | Parallel word |
| ser_o | output | 1 | Current head bit of the shift register |
| busy_o | output | 1 | A word still has bits left to shift |

## Verification
A wrong bit counter shows up at `busy_o`. It drops a shift early or late within the same word, or it never drops, so the feeder stalls and the next load is refused. A wrong shift direction or a wrong fill value shows up on `ser_o` within one shift of the fault. A broken arbitration shows up as a corrupted stream right after a load was tried in the middle of a word. Every scenario therefore compares `ser_o` bit by bit and samples `busy_o` before and after the eighth shift.

// File: rtl/ser_pkg.sv
// Shared types for the word shifter: the single operation chosen per cycle.
package ser_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_CLEAR = 2'd3
    } ser_op_e;
endpackage

// File: rtl/ser_arbiter.sv
// Picks one operation per cycle from the strobes.
// Priority: clear, then load (only when idle), then shift (only when busy).
// Assumes busy_i comes from the bit counter's registered state.
module ser_arbiter
    import ser_pkg::*;
(
    input  logic    clr_i,
    input  logic    load_i,
    input  logic    shift_i,
    input  logic    busy_i,
    output ser_op_e op_o
);
    // Operation select: a load is refused while a word is pending
    always_comb begin
        if (clr_i)                 op_o = OP_CLEAR;
        else if (load_i && !busy_i) op_o = OP_LOAD;
        else if (shift_i && busy_i) op_o = OP_SHIFT;
        else                       op_o = OP_HOLD;
    end
endmodule

// File: rtl/ser_counter.sv
// Counts bits still to be sent: reloads to DW on load, steps down on shift.
// Assumes the arbiter issues OP_SHIFT only while the count is non-zero.
module ser_counter
    import ser_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ser_op_e       op_i,
    output logic [CW-1:0] cnt_o,
    output logic          busy_o
);
    logic [CW-1:0] cnt_q;

    // Remaining-bit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (op_i)
                OP_CLEAR: cnt_q <= '0;
                OP_LOAD:  cnt_q <= CW'(DW);
                OP_SHIFT: cnt_q <= cnt_q - CW'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ser_shreg.sv
// Data register: loads a word, shifts toward the selected end, fills with 0.
// Assumes lsb_first_i stays constant within a word; it steers both the
// shift direction and the output tap.
module ser_shreg
    import ser_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ser_op_e       op_i,
    input  logic          lsb_first_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] q_o,
    output logic          ser_o
);
    logic [DW-1:0] q;
    logic [DW-1:0] shifted;

    // Next value of each bit for one shift step, per direction
    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic from_lower;
        logic from_upper;
        if (i == 0) begin : g_lo_end
            assign from_lower = 1'b0;
        end else begin : g_lo_mid
            assign from_lower = q[i-1];
        end
        if (i == DW - 1) begin : g_hi_end
            assign from_upper = 1'b0;
        end else begin : g_hi_mid
            assign from_upper = q[i+1];
        end
        assign shifted[i] = lsb_first_i ? from_upper : from_lower;
    end

    // Shift register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op_i)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= data_i;
                OP_SHIFT: q <= shifted;
                default:  q <= q;
            endcase
        end
    end

    assign q_o   = q;
    assign ser_o = lsb_first_i ? q[0] : q[DW-1];
endmodule

// File: rtl/word_serializer.sv
// Top level: arbiter, bit counter and shift register for one byte stream.
// Assumes strobes are synchronous to clk and one cycle wide per request.
module word_serializer
    import ser_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          lsb_first_i,
    input  logic          load_i,
    input  logic          shift_i,
    input  logic [DW-1:0] data_i,
    output logic          ser_o,
    output logic          busy_o
);
    ser_op_e       op;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;

    ser_arbiter u_arb (
        .clr_i   (clr_i),
        .load_i  (load_i),
        .shift_i (shift_i),
        .busy_i  (busy_o),
        .op_o    (op)
    );

    ser_counter #(.DW(DW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .cnt_o  (cnt),
        .busy_o (busy_o)
    );

    ser_shreg #(.DW(DW)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .lsb_first_i (lsb_first_i),
        .data_i      (data_i),
        .q_o         (shreg),
        .ser_o       (ser_o)
    );
endmodule

// File: rtl/ser_checker.sv
// Temporal checks on the word shifter, bound to every word_serializer.
module ser_checker #(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_i,
    input logic          load_i,
    input logic          shift_i,
    input logic          busy_o,
    input logic [CW-1:0] cnt,
    input logic [DW-1:0] shreg
);
    p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o && !clr_i) |=> busy_o);

    p_load_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && busy_o && !shift_i && !clr_i) |=> ($stable(shreg) && $stable(cnt)));

    p_idle_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !busy_o && !load_i && !clr_i) |=> ($stable(shreg) && !busy_o));

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && busy_o && !clr_i) |=> (cnt == $past(cnt) - CW'(1)));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!busy_o && shreg == '0));
endmodule

bind word_serializer ser_checker #(.DW(DW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .load_i  (load_i),
    .shift_i (shift_i),
    .busy_o  (busy_o),
    .cnt     (cnt),
    .shreg   (shreg)
);

// File: tb/sim_word_serializer.sv
module sim_word_serializer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       lsb_first_i = 1'b0;
    logic       load_i = 1'b0;
    logic       shift_i = 1'b0;
    logic [7:0] data_i = '0;
    logic       ser_o;
    logic       busy_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    word_serializer u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .lsb_first_i(lsb_first_i),
        .load_i(load_i), .shift_i(shift_i), .data_i(data_i),
        .ser_o(ser_o), .busy_o(busy_o)
    );

    // advance one edge, land just after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic head(input logic [7:0] d, input logic lsb, input int k);
        return lsb ? d[k] : d[7-k];
    endfunction

    task automatic idle_inputs();
        load_i = 0; shift_i = 0; clr_i = 0;
    endtask

    // full word in the given order; R2, R3/R4, R5, R9
    task automatic t_word(input logic [7:0] d, input logic lsb);
        lsb_first_i = lsb; data_i = d; load_i = 1;
        step();
        idle_inputs();
        check("R2 busy after load", busy_o, 1);
        for (int k = 0; k < 8; k++) begin
            check(lsb ? "R4 lsb bit" : "R3 msb bit", ser_o, head(d, lsb, k));
            if (k == 7) check("R9 busy before last shift", busy_o, 1);
            shift_i = 1; step(); shift_i = 0;
        end
        check("R9 busy after 8 shifts", busy_o, 0);
        check("R5 zero fill", ser_o, 0);
    endtask

    // load refused mid-word, with and without a shift; R6, R9
    task automatic t_load_busy();
        logic [7:0] a = 8'hC6;
        lsb_first_i = 0; data_i = a; load_i = 1;
        step(); idle_inputs();
        shift_i = 1; step(); step(); shift_i = 0;
        data_i = 8'h3F; load_i = 1;
        step(); load_i = 0;
        check("R6 load refused keeps word", ser_o, head(a, 0, 2));
        check("R6 still busy", busy_o, 1);
        data_i = 8'h00; load_i = 1; shift_i = 1;
        step(); idle_inputs();
        check("R6 shift advances while load refused", ser_o, head(a, 0, 3));
        for (int k = 4; k < 8; k++) begin
            shift_i = 1; step(); shift_i = 0;
            check("R6 remaining bits of first word", ser_o, head(a, 0, k));
        end
        check("R9 busy before final shift", busy_o, 1);
        shift_i = 1; step(); shift_i = 0;
        check("R9 busy drops on eighth shift", busy_o, 0);
    endtask

    // load and shift together when idle; R7
    task automatic t_load_and_shift();
        logic [7:0] d = 8'h5A;
        lsb_first_i = 1; data_i = d; load_i = 1; shift_i = 1;
        step(); idle_inputs();
        check("R7 load wins", ser_o, head(d, 1, 0));
        check("R7 busy", busy_o, 1);
        for (int k = 1; k < 8; k++) begin
            shift_i = 1; step(); shift_i = 0;
            check("R7 following bit", ser_o, head(d, 1, k));
        end
        shift_i = 1; step(); shift_i = 0;
        check("R7 full eight bits", busy_o, 0);
    endtask

    // shifts while idle do nothing; R8
    task automatic t_idle_shift();
        shift_i = 1;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R8 idle shift busy", busy_o, 0);
            check("R8 idle shift ser", ser_o, 0);
        end
        shift_i = 0;
    endtask

    // synchronous clear beats load; R10
    task automatic t_clear();
        lsb_first_i = 0; data_i = 8'hFF; load_i = 1;
        step(); idle_inputs();
        shift_i = 1; step(); step(); step(); shift_i = 0;
        check("R10 pre-clear ser", ser_o, 1);
        clr_i = 1; load_i = 1; shift_i = 1; data_i = 8'hFF;
        step(); idle_inputs();
        check("R10 clear busy", busy_o, 0);
        check("R10 clear ser", ser_o, 0);
        t_word(8'h81, 0);
    endtask

    initial begin
        repeat (3) step();
        check("R1 reset busy", busy_o, 0);
        check("R1 reset ser", ser_o, 0);
        rst_n = 1;
        step();
        t_word(8'hB2, 0);
        t_word(8'hB2, 1);
        t_word(8'h01, 0);
        t_word(8'h80, 1);
        t_load_busy();
        t_load_and_shift();
        t_idle_shift();
        t_clear();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule